// File: doc/BRIEF.md
# PCM Serial Audio Transmitter

This block sends stereo PCM samples to an external digital-to-analog converter over a three-wire serial link. It drives a bit clock, a word clock that marks the left and right halves of each frame, and a serial data line. A sample pair (left and right words) enters through a valid/ready handshake and waits in a single holding register until the next frame begins. At that point it becomes the pair that is shifted out.

Several settings are chosen at run time by configuration inputs: sample precision, bit order, slot length (16 or 32 bit clocks per channel), the placement of the sample inside a 32-cycle slot, and which bit-clock edge the data moves on. The bit clock is divided down from the system clock. The configuration is sampled once per frame, at the start of the left slot, so a frame never mixes two formats. If no new pair is waiting when a frame starts, the previous pair is sent again and an underrun indication is raised for that frame.

Top module: `pcm_serial_tx`

## Requirements
- R1: The bit clock period is 2*(cfg_div+1) system clock cycles. Each half lasts cfg_div+1 cycles.
- R2: The word clock is low during the left slot and high during the right slot. A slot is 16 bit clocks long when cfg_slot32=0 and 32 when cfg_slot32=1. The word clock changes only on the edge where the data changes.
- R3: cfg_prec selects the precision: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. A sample of p bits is taken from bits p-1..0 of in_left or in_right. Input bits above p-1 are ignored.
- R4: With cfg_lsb_first=0 each word is sent most significant bit first. With cfg_lsb_first=1 it is sent least significant bit first.
- R5: In a 32-cycle slot, every bit position that does not carry sample data is driven as 0.
- R6: With cfg_right_just=1, the last sample bit falls on the last bit clock of the slot. With cfg_right_just=0, the first sample bit falls on the first bit clock of the slot, or on the second one when cfg_delay1=1. cfg_delay1 is ignored when cfg_right_just=1.
- R7: In 16-cycle slots the precision is forced to 16 bits and cfg_delay1 is forced to 0, whatever the inputs say.
- R8: With cfg_bclk_pol=0, sdata and wclk change on the falling edge of bclk and are stable at its rising edge. With cfg_bclk_pol=1 the roles of the two edges are swapped.
- R9: in_ready is high while the holding register is empty. After a pair is accepted (in_valid and in_ready both high at a clock edge), in_ready is low until that pair is moved into the transmit registers at the next frame start.
- R10: At a frame start with no pair held, the previous pair is sent again and underrun is 1 for that frame. A frame that takes a new pair has underrun at 0.
- R11: All format inputs, including cfg_bclk_pol, are sampled at the frame start. A change made during a frame takes effect in the following frame.
- R12: During reset, bclk=1, wclk=1, sdata=0, in_ready=1 and underrun=0. The first bit clock period after reset starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Bit-clock half-period in system cycles, minus one |
| cfg_prec | input | 2 | Precision code (16/18/20/24 bits) |
| cfg_lsb_first | input | 1 | 1: send least significant bit first |
| cfg_slot32 | input | 1 | 1: 32-cycle slots, 0: 16-cycle slots |
| cfg_right_just | input | 1 | 1: sample ends at the slot's last bit |
| cfg_delay1 | input | 1 | 1: left-placed sample starts one bit late |
| cfg_bclk_pol | input | 1 | 1: data changes on the rising bit-clock edge |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W | Left sample, right-aligned |
| in_right | input | SAMPLE_W | Right sample, right-aligned |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock (low = left) |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
sdata and wclk are registered on the system edge that ends a bit-clock period. They are due at the opposite bit-clock edge, cfg_div+1 system cycles later. The bench acts as the receiver: it waits for that sampling edge, then reads the lines at the next falling system clock edge, so every read falls in the middle of a stable bit. underrun is read at the first bit of each frame, one half bit after the load. in_ready is read one system cycle after an acceptance. A sample pair and a format pushed during frame n are expected in frame n+1, and the checks of frame n use only what was pushed during frame n-1.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  // Frame positions: up to two 32-cycle slots
  localparam int POS_W = 6;

  typedef enum logic [1:0] {
    PREC_16 = 2'd0,
    PREC_18 = 2'd1,
    PREC_20 = 2'd2,
    PREC_24 = 2'd3
  } prec_e;

  typedef struct packed {
    prec_e prec;
    logic  lsb_first;
    logic  slot32;
    logic  right_just;
    logic  delay1;
    logic  bclk_pol;
  } fmt_t;

  function automatic logic [POS_W-1:0] prec_len(input prec_e p);
    logic [POS_W-1:0] n;
    case (p)
      PREC_18: n = POS_W'(18);
      PREC_20: n = POS_W'(20);
      PREC_24: n = POS_W'(24);
      default: n = POS_W'(16);
    endcase
    return n;
  endfunction

  // Short slots hold only 16-bit words and carry no delay bit
  function automatic fmt_t fmt_legalize(input fmt_t f);
    fmt_t g;
    g = f;
    if (!g.slot32) begin
      g.prec   = PREC_16;
      g.delay1 = 1'b0;
    end
    return g;
  endfunction

endpackage

// File: rtl/pcm_tx_bitclk.sv
module pcm_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  output logic             phase,
  output logic             bit_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             wrap;

  always_comb begin
    wrap     = (cnt_q >= half_div);
    cnt_d    = wrap ? '0 : cnt_q + 1'b1;
    ph_d     = wrap ? ~ph_q : ph_q;
    bit_tick = wrap && ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

  // R1
  ph_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_q) |-> $past(cnt_q >= half_div));

endmodule

// File: rtl/pcm_tx_sample_buf.sv
module pcm_tx_sample_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                load,
  output logic                in_ready,
  output logic [SAMPLE_W-1:0] left_nx,
  output logic [SAMPLE_W-1:0] right_nx,
  output logic                underrun
);

  logic                hold_full_q, hold_full_d;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q;
  logic                under_q, under_d;
  logic                accept, take, hold_en;

  always_comb begin
    accept      = in_valid && !hold_full_q;
    take        = load && hold_full_q;
    hold_en     = accept;
    hold_full_d = load ? accept : (hold_full_q || accept);
    under_d     = load ? !hold_full_q : under_q;
    left_nx     = take ? hold_l_q : cur_l_q;
    right_nx    = take ? hold_r_q : cur_r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      under_q     <= 1'b0;
    end else begin
      hold_full_q <= hold_full_d;
      under_q     <= under_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (hold_en) begin
      hold_l_q <= in_left;
      hold_r_q <= in_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l_q <= '0;
      cur_r_q <= '0;
    end else if (take) begin
      cur_l_q <= hold_l_q;
      cur_r_q <= hold_r_q;
    end
  end

  assign in_ready = !hold_full_q;
  assign underrun = under_q;

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  underrun_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(under_q) |-> $past(load));

endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  fmt_t                fmt_in,
  input  logic [SAMPLE_W-1:0] left_nx,
  input  logic [SAMPLE_W-1:0] right_nx,
  output logic                load,
  output logic                bclk_pol,
  output logic                wclk,
  output logic                sdata
);

  localparam int FRAME_MAX = 1 << POS_W;
  localparam int PAD_W     = FRAME_MAX - SAMPLE_W;
  localparam logic [POS_W-1:0] LAST16 = POS_W'(31);
  localparam logic [POS_W-1:0] LAST32 = POS_W'(63);
  localparam logic [POS_W-1:0] SLOT16 = POS_W'(16);
  localparam logic [POS_W-1:0] SLOT32 = POS_W'(32);

  fmt_t                 fmt_q, fmt_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic [POS_W-1:0]     last_pos, slot_len, idx, off, rel, bsel, plen;
  logic                 wclk_q, wclk_d, sdata_q, sdata_d;
  logic                 right_half, in_win;
  logic [FRAME_MAX-1:0] word_pad;

  // Next-state: everything describes the bit that starts at this tick
  always_comb begin
    last_pos   = fmt_q.slot32 ? LAST32 : LAST16;
    load       = bit_tick && (pos_q >= last_pos);
    fmt_d      = load ? fmt_legalize(fmt_in) : fmt_q;
    pos_d      = load ? '0 : pos_q + 1'b1;
    slot_len   = fmt_d.slot32 ? SLOT32 : SLOT16;
    right_half = (pos_d >= slot_len);
    idx        = right_half ? pos_d - slot_len : pos_d;
    plen       = prec_len(fmt_d.prec);
    off        = fmt_d.right_just ? slot_len - plen
                                  : {{(POS_W-1){1'b0}}, fmt_d.delay1};
    rel        = idx - off;
    in_win     = (idx >= off) && (rel < plen);
    bsel       = fmt_d.lsb_first ? rel : plen - 1'b1 - rel;
    word_pad   = right_half ? {{PAD_W{1'b0}}, right_nx}
                            : {{PAD_W{1'b0}}, left_nx};
    wclk_d     = right_half;
    sdata_d    = in_win ? word_pad[bsel] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= LAST16;
      fmt_q   <= '0;
      wclk_q  <= 1'b1;
      sdata_q <= 1'b0;
    end else if (bit_tick) begin
      pos_q   <= pos_d;
      fmt_q   <= fmt_d;
      wclk_q  <= wclk_d;
      sdata_q <= sdata_d;
    end
  end

  assign bclk_pol = fmt_q.bclk_pol;
  assign wclk     = wclk_q;
  assign sdata    = sdata_q;

  // R2
  wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wclk_q) |-> $past(bit_tick));

  // R8
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(sdata_q));

  // R11
  fmt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(fmt_q));

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_prec,
  input  logic                cfg_lsb_first,
  input  logic                cfg_slot32,
  input  logic                cfg_right_just,
  input  logic                cfg_delay1,
  input  logic                cfg_bclk_pol,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk,
  output logic                wclk,
  output logic                sdata,
  output logic                underrun
);

  fmt_t                fmt_in;
  logic                phase, bit_tick, load, bclk_pol;
  logic [SAMPLE_W-1:0] left_nx, right_nx;

  always_comb begin
    fmt_in.prec       = prec_e'(cfg_prec);
    fmt_in.lsb_first  = cfg_lsb_first;
    fmt_in.slot32     = cfg_slot32;
    fmt_in.right_just = cfg_right_just;
    fmt_in.delay1     = cfg_delay1;
    fmt_in.bclk_pol   = cfg_bclk_pol;
  end

  pcm_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_div (cfg_div),
    .phase    (phase),
    .bit_tick (bit_tick)
  );

  pcm_tx_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .load     (load),
    .in_ready (in_ready),
    .left_nx  (left_nx),
    .right_nx (right_nx),
    .underrun (underrun)
  );

  pcm_tx_framer #(.SAMPLE_W(SAMPLE_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .fmt_in   (fmt_in),
    .left_nx  (left_nx),
    .right_nx (right_nx),
    .load     (load),
    .bclk_pol (bclk_pol),
    .wclk     (wclk),
    .sdata    (sdata)
  );

  // Raw phase is high in the half that ends with a data change
  assign bclk = phase ^ bclk_pol;

endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;

  logic          clk, rst_n;
  logic [7:0]    cfg_div;
  logic [1:0]    cfg_prec;
  logic          cfg_lsb_first, cfg_slot32, cfg_right_just, cfg_delay1, cfg_bclk_pol;
  logic          in_valid, in_ready;
  logic [SW-1:0] in_left, in_right;
  logic          bclk, wclk, sdata, underrun;

  int vectors = 0;
  int errors  = 0;

  // model of the frame on the wire
  int            cur_pc;
  bit            cur_lsb, cur_s32, cur_rj, cur_d1;
  logic [SW-1:0] cur_l, cur_r;
  bit            exp_under;
  bit            pol;
  int            div_v;
  logic          prev_w;
  time           t_prev, t_last;

  pcm_serial_tx #(.SAMPLE_W(SW), .DIV_W(8)) i_pcm_serial_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_prec(cfg_prec),
    .cfg_lsb_first(cfg_lsb_first), .cfg_slot32(cfg_slot32),
    .cfg_right_just(cfg_right_just), .cfg_delay1(cfg_delay1),
    .cfg_bclk_pol(cfg_bclk_pol), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .bclk(bclk), .wclk(wclk),
    .sdata(sdata), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [SW-1:0] w, input int k, input bit s32,
                                   input int pc, input bit lsb, input bit rj, input bit d1);
    int slot, p, off, j;
    slot = s32 ? 32 : 16;
    if (!s32) p = 16;
    else case (pc)
      1: p = 18;
      2: p = 20;
      3: p = 24;
      default: p = 16;
    endcase
    off = rj ? slot - p : ((s32 && d1) ? 1 : 0);
    j = k - off;
    if (j < 0 || j >= p) return 1'b0;
    return lsb ? w[j] : w[p-1-j];
  endfunction

  function automatic logic [63:0] exp_frame();
    logic [63:0] v;
    int slot;
    v = '0;
    slot = cur_s32 ? 32 : 16;
    for (int k = 0; k < 2*slot; k++)
      v[k] = exp_bit((k < slot) ? cur_l : cur_r, k % slot, cur_s32, cur_pc, cur_lsb, cur_rj, cur_d1);
    return v;
  endfunction

  task automatic get_bit(output logic b, output logic w);
    if (pol) @(negedge bclk); else @(posedge bclk);
    t_prev = t_last;
    t_last = $time;
    @(negedge clk);
    b = sdata;
    w = wclk;
  endtask

  task automatic set_cfg(input int pc, input bit lsb, input bit s32, input bit rj, input bit d1);
    cfg_prec       = 2'(pc);
    cfg_lsb_first  = lsb;
    cfg_slot32     = s32;
    cfg_right_just = rj;
    cfg_delay1     = d1;
  endtask

  task automatic start(input bit p, input int d, input int pc, input bit lsb,
                       input bit s32, input bit rj, input bit d1);
    rst_n = 1'b0;
    in_valid = 1'b0;
    pol = p;
    div_v = d;
    cfg_div = 8'(d);
    cfg_bclk_pol = p;
    set_cfg(pc, lsb, s32, rj, d1);
    cur_pc = pc; cur_lsb = lsb; cur_s32 = s32; cur_rj = rj; cur_d1 = d1;
    repeat (3) @(negedge clk);
    // R12 reset values {bclk,wclk,sdata,in_ready,underrun}
    check("R12 reset state", 64'({bclk, wclk, sdata, in_ready, underrun}), 64'(5'b11010));
    rst_n = 1'b1;
    cur_l = SW'($urandom);
    cur_r = SW'($urandom);
    in_left = cur_l;
    in_right = cur_r;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_under = 1'b0;
    prev_w = 1'b1;
    t_last = 0;
  endtask

  // Checks the frame now starting; pushes the pair and format for the next one
  task automatic do_frame(input bit push, input int pc, input bit lsb, input bit s32,
                          input bit rj, input bit d1, input string tag);
    logic b, w;
    logic [63:0] got, wgot, wexp;
    logic [SW-1:0] nl, nr;
    int slot;
    nl = '0; nr = '0;
    get_bit(b, w);
    while (!(w == 1'b0 && prev_w == 1'b1)) begin
      prev_w = w;
      get_bit(b, w);
    end
    got = '0; wgot = '0;
    got[0] = b; wgot[0] = w;
    check({tag, " R10 underrun flag"}, 64'(underrun), 64'(exp_under));
    check("R9 ready while holding register empty", 64'(in_ready), 64'(1));
    set_cfg(pc, lsb, s32, rj, d1);
    if (push) begin
      nl = SW'($urandom);
      nr = SW'($urandom);
      in_left = nl;
      in_right = nr;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 ready low after accept", 64'(in_ready), 64'(0));
    end
    slot = cur_s32 ? 32 : 16;
    for (int k = 1; k < 2*slot; k++) begin
      get_bit(b, w);
      got[k] = b;
      wgot[k] = w;
    end
    prev_w = w;
    wexp = '0;
    for (int k = slot; k < 2*slot; k++) wexp[k] = 1'b1;
    check({tag, " R11 frame data"}, got, exp_frame());
    check("R2 word clock per bit", wgot, wexp);
    check("R1 bit clock period", 64'(t_last - t_prev), 64'(2*(div_v+1)*CLK_PERIOD));
    if (push) begin
      cur_l = nl;
      cur_r = nr;
      exp_under = 1'b0;
    end else begin
      exp_under = 1'b1;
    end
    cur_pc = pc; cur_lsb = lsb; cur_s32 = s32; cur_rj = rj; cur_d1 = d1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_left = '0;
    in_right = '0;
    // segment A: data changes on falling bclk
    start(1'b0, 2, 3, 1'b0, 1'b1, 1'b0, 1'b0);
    do_frame(1'b1, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R5 R6 R8 24-bit MSB-first");
    do_frame(1'b1, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 LSB-first");
    do_frame(1'b1, 2, 1'b0, 1'b1, 1'b0, 1'b1, "R6 right-justified 18-bit");
    do_frame(1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b1, "R6 one-bit delay 20-bit");
    do_frame(1'b0, 3, 1'b1, 1'b0, 1'b0, 1'b1, "R7 16-cycle slot forces 16-bit");
    do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b1, "R10 repeated pair, R7 LSB");
    do_frame(1'b1, 1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 delay ignored when right-justified");
    for (int i = 0; i < 24; i++)
      do_frame(($urandom % 5) != 0, int'($urandom % 4), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), "R3 R4 R5 R6 random");
    // segment B: data changes on rising bclk
    start(1'b1, 1, 2, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 24; i++)
      do_frame(($urandom % 4) != 0, int'($urandom % 4), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), "R8 rising-edge change");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule